// File: doc/BRIEF.md
# Multiplexed Bus Character Display Write Bridge

This block lets a host write to, and start reads from, a character display that sits on a legacy multiplexed address/data bus. The bus has no chip-select lines. For each accepted request the block runs one bus cycle:

- It drives the low address byte onto the shared 8-bit lines and pulses an address latch strobe.
- It replaces the address with the write data and sets the read/write line.
- It raises the bus E clock.

The display enable is E gated by a decode of the upper address nibble, so display writes are clocked in on the falling edge of E, inside the bus cycle, and not by a separate write strobe. Register select comes from address bit 0.

E is a quarter-rate clock: two system clocks low, two high. It runs freely while the bridge is idle and stays in step with every bus cycle. A two-bit wait setting, sampled with the request, stretches the high phase of E by whole E periods for slow displays. Addresses outside the display window still get a complete bus cycle, but the display enable never rises.

Top module: `lcd_mux_bridge`

## Requirements
- R1: While reset is held and right after it is released, E, the display enable and the latch strobe are low, R/W is high (read), the AD lines are not driven (ad_oe low) and req_ready is high.
- R2: An accepted request produces exactly one one-clock latch strobe. During it, ad_oe is high, ad_out equals address bits 7:0, addr_hi equals address bits 15:8 and E is low.
- R3: On the clock after the strobe, R/W takes its cycle value (0 = write, 1 = read). For a write, ad_out carries the write data with ad_oe high from that clock through the high phase of E and for one more clock after E falls. For a read, ad_oe stays low from that clock until the cycle ends.
- R4: Outside bus cycles, E repeats two clocks low then two clocks high. In a cycle, E is low during the strobe clock and the data clock and rises on the clock after the data clock.
- R5: The display enable is high only when E is high and address bits 15:12 equal 4'b0011. In such a cycle it equals E for the whole high phase.
- R6: rs equals address bit 0 (0 = control register, 1 = data register) from the strobe clock until the next request.
- R7: Every address 0x3000 to 0x3FFF reaches the display. Any other address runs the same bus cycle with the display enable held low.
- R8: req_ready is high only between cycles. It is low from the clock after acceptance until the clock after E falls, and request inputs that change while it is low do not alter the running cycle.
- R9: The high phase of E in a cycle lasts 2 + 4*W clocks, where W is the wait setting (0 to 3) sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| wait_cfg | input | 2 | Extra E periods added to the high phase |
| ad_out | output | 8 | Multiplexed address/data output value |
| ad_oe | output | 1 | Output enable for the AD lines |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rw | output | 1 | Read/write line, 1 = read |
| rs | output | 1 | Display register select |
| e_clk | output | 1 | Quarter-rate bus E clock |
| lcd_en | output | 1 | Display enable (decoded E) |

## Verification
A sequencer stuck in or skipping a phase shows up at the ports within one E period. It appears as a missing or doubled latch strobe, data reaching the AD lines in the same clock as the address, or an E high phase whose length differs from 2 + 4*W. A wrong captured address or wait setting shows up on addr_hi, rs or the display enable during the very cycle it corrupts. A lost hold clock shows up as the data disappearing on the clock E falls. Random addresses inside and outside the window, random wait settings, and directed edges of the window cover these.

// File: rtl/lcd_bridge_pkg.sv
package lcd_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ADDR,
    ST_DATA,
    ST_STROBE,
    ST_HOLD
  } cyc_state_t;

  // Quarter-rate E: half the period low, half high; each wait adds a period.
  function automatic int unsigned strobe_clocks(input int unsigned waits,
                                                input int unsigned e_div);
    return (e_div / 2) + waits * e_div;
  endfunction

  function automatic logic window_match(input logic [3:0] nibble,
                                        input logic [3:0] tag);
    return nibble == tag;
  endfunction

endpackage

// File: rtl/lcd_ephase_gen.sv
module lcd_ephase_gen #(
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reload,
  output logic [QW-1:0] phase_q,
  output logic          e_free
);
  // Counter value after the hold clock, so that E stays low for a half period.
  localparam logic [QW-1:0] RELOAD_VAL = QW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (reload) phase_q <= RELOAD_VAL;
    else if (run)    phase_q <= phase_q + 1'b1;
  end

  assign e_free = phase_q[QW-1];

endmodule

// File: rtl/lcd_cycle_seq.sv
module lcd_cycle_seq
  import lcd_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WS_W   = 2,
  parameter int QW     = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [WS_W-1:0]   wait_cfg,
  input  logic [QW-1:0]     phase_q,
  output cyc_state_t        state,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              cap_write,
  output logic              accept_evt,
  output logic              strobe_end,
  output logic              run_phase,
  output logic              reload_phase
);
  localparam int unsigned E_DIV = 2 ** QW;

  cyc_state_t      state_nx;
  logic [WS_W-1:0] cap_ws;
  logic [CNT_W-1:0] strobe_cnt;
  logic            phase_last;

  assign accept_evt   = req_valid && (state == ST_IDLE);
  assign phase_last   = (phase_q == {QW{1'b1}});
  assign strobe_end   = (state == ST_STROBE) && (strobe_cnt == '0);
  assign run_phase    = (state == ST_IDLE) || (state == ST_SYNC);
  assign reload_phase = (state == ST_HOLD);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept_evt) state_nx = ST_SYNC;
      ST_SYNC:   if (phase_last) state_nx = ST_ADDR;
      ST_ADDR:   state_nx = ST_DATA;
      ST_DATA:   state_nx = ST_STROBE;
      ST_STROBE: if (strobe_end) state_nx = ST_HOLD;
      ST_HOLD:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_write <= 1'b0;
      cap_ws    <= '0;
    end else if (accept_evt) begin
      cap_addr  <= req_addr;
      cap_wdata <= req_wdata;
      cap_write <= req_write;
      cap_ws    <= wait_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      strobe_cnt <= '0;
    else if (state == ST_DATA)
      strobe_cnt <= CNT_W'(strobe_clocks(32'(cap_ws), E_DIV) - 1);
    else if (state == ST_STROBE && !strobe_end)
      strobe_cnt <= strobe_cnt - 1'b1;
  end

endmodule

// File: rtl/lcd_bus_drive.sv
module lcd_bus_drive
  import lcd_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  cyc_state_t        state,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_wdata,
  input  logic              cap_write,
  input  logic              e_free,
  input  logic              bus_active,
  input  logic              lcd_hit,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              ale,
  output logic              rw,
  output logic              rs,
  output logic              e_clk
);
  logic addr_phase;
  logic data_phase;

  assign addr_phase = (state == ST_ADDR);
  assign data_phase = (state == ST_DATA) || (state == ST_STROBE) ||
                      (state == ST_HOLD);

  always_comb begin
    if (state == ST_STROBE) e_clk = 1'b1;
    else if (bus_active)    e_clk = 1'b0;
    else                    e_clk = e_free;
  end

  assign ale     = addr_phase;
  assign ad_oe   = addr_phase || (data_phase && cap_write);
  assign addr_hi = cap_addr[ADDR_W-1:DATA_W];
  assign rw      = data_phase ? ~cap_write : 1'b1;
  assign rs      = cap_addr[0];

  always_comb begin
    if (addr_phase)                      ad_out = cap_addr[DATA_W-1:0];
    else if (data_phase && cap_write)    ad_out = cap_wdata;
    else                                 ad_out = '0;
  end

  // lcd_hit is consumed in the top; kept as an input so the drive view is complete.
  logic unused_hit;
  assign unused_hit = lcd_hit;

endmodule

// File: rtl/lcd_mux_bridge.sv
module lcd_mux_bridge
  import lcd_bridge_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         DATA_W  = 8,
  parameter int         WS_W    = 2,
  parameter logic [3:0] WIN_TAG = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [WS_W-1:0]   wait_cfg,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              ale,
  output logic              rw,
  output logic              rs,
  output logic              e_clk,
  output logic              lcd_en
);
  localparam int          QW        = 2;
  localparam int          HI_W      = ADDR_W - DATA_W;
  localparam int unsigned STRB_MAX  = strobe_clocks(2 ** WS_W - 1, 2 ** QW);
  localparam int          CNT_W     = $clog2(STRB_MAX + 1);

  cyc_state_t        state;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_write;
  logic [QW-1:0]     phase_q;
  logic              e_free;
  logic              accept_evt;
  logic              strobe_end;
  logic              run_phase;
  logic              reload_phase;

  // Named internal events, observed by the bound checker.
  logic              bus_active;
  logic              lcd_hit;

  lcd_ephase_gen #(.QW(QW)) u_ephase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_phase),
    .reload  (reload_phase),
    .phase_q (phase_q),
    .e_free  (e_free)
  );

  lcd_cycle_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W), .QW(QW), .CNT_W(CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_write    (req_write),
    .wait_cfg     (wait_cfg),
    .phase_q      (phase_q),
    .state        (state),
    .cap_addr     (cap_addr),
    .cap_wdata    (cap_wdata),
    .cap_write    (cap_write),
    .accept_evt   (accept_evt),
    .strobe_end   (strobe_end),
    .run_phase    (run_phase),
    .reload_phase (reload_phase)
  );

  assign bus_active = (state == ST_ADDR) || (state == ST_DATA) ||
                      (state == ST_STROBE) || (state == ST_HOLD);
  assign lcd_hit    = window_match(cap_addr[ADDR_W-1 -: 4], WIN_TAG);
  assign req_ready  = (state == ST_IDLE);

  lcd_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .state      (state),
    .cap_addr   (cap_addr),
    .cap_wdata  (cap_wdata),
    .cap_write  (cap_write),
    .e_free     (e_free),
    .bus_active (bus_active),
    .lcd_hit    (lcd_hit),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .addr_hi    (addr_hi),
    .ale        (ale),
    .rw         (rw),
    .rs         (rs),
    .e_clk      (e_clk)
  );

  assign lcd_en = lcd_hit && bus_active && e_clk;

  logic unused_evt;
  assign unused_evt = accept_evt ^ strobe_end ^ HI_W[0];

endmodule

// File: rtl/lcd_bridge_checker.sv
module lcd_bridge_checker #(
  parameter int         DATA_W  = 8,
  parameter int         HI_W    = 8,
  parameter logic [3:0] WIN_TAG = 4'h3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [DATA_W-1:0] ad_out,
  input logic              ad_oe,
  input logic [HI_W-1:0]   addr_hi,
  input logic              ale,
  input logic              rw,
  input logic              rs,
  input logic              e_clk,
  input logic              lcd_en,
  input logic              bus_active
);
  AST_EN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> (e_clk && addr_hi[HI_W-1 -: 4] == WIN_TAG)); // R5
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && !e_clk)); // R2
  AST_ALE_THEN_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !e_clk); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(e_clk) && !rw) |-> (ad_oe && $stable(ad_out))); // R3
  AST_RS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> $stable(rs)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> !req_ready); // R8
  AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lcd_en); // R8
endmodule

bind lcd_mux_bridge lcd_bridge_checker #(
  .DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W), .WIN_TAG(WIN_TAG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .ad_out     (ad_out),
  .ad_oe      (ad_oe),
  .addr_hi    (addr_hi),
  .ale        (ale),
  .rw         (rw),
  .rs         (rs),
  .e_clk      (e_clk),
  .lcd_en     (lcd_en),
  .bus_active (bus_active)
);

// File: tb/lcd_mux_bridge_bench.sv
module lcd_mux_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic [1:0]  wait_cfg = '0;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  addr_hi;
  logic        ale, rw, rs, e_clk, lcd_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_bridge u_lcd_mux_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .wait_cfg(wait_cfg), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .ale(ale), .rw(rw), .rs(rs), .e_clk(e_clk), .lcd_en(lcd_en)
  );

  function automatic logic exp_hit(input logic [15:0] a);
    return (a >= 16'h3000) && (a < 16'h4000);
  endfunction

  function automatic int exp_high_len(input int ws);
    return 4 * ws + 2;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic wr, input int ws, input logic poke);
    int n;
    logic hit;
    hit = exp_hit(a);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = wr;
    wait_cfg = 2'(ws);
    @(negedge clk);
    if (poke) begin
      req_addr = ~a; req_wdata = ~d; req_write = ~wr; wait_cfg = 2'(3 - ws);
    end else begin
      req_valid = 1'b0;
    end
    chk(req_ready == 1'b0, "R8 ready after accept", int'(req_ready), 0);
    n = 0;
    while (!ale && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk(ale == 1'b1, "R2 latch strobe seen", int'(ale), 1);
    chk(ad_oe && ad_out == a[7:0], "R2 low address on AD", int'(ad_out), int'(a[7:0]));
    chk(addr_hi == a[15:8], "R2 high address", int'(addr_hi), int'(a[15:8]));
    chk(e_clk == 1'b0 && lcd_en == 1'b0, "R4 E low at strobe", int'(e_clk), 0);
    chk(rs == a[0], "R6 register select", int'(rs), int'(a[0]));
    @(negedge clk);
    chk(ale == 1'b0, "R2 strobe one clock", int'(ale), 0);
    chk(rw == !wr, "R3 rw in data phase", int'(rw), int'(!wr));
    chk(e_clk == 1'b0, "R4 E low in data phase", int'(e_clk), 0);
    if (wr) chk(ad_oe && ad_out == d, "R3 write data driven", int'(ad_out), int'(d));
    else    chk(!ad_oe, "R3 read releases AD", int'(ad_oe), 0);
    for (int i = 0; i < exp_high_len(ws); i++) begin
      @(negedge clk);
      chk(e_clk == 1'b1, "R9 E high length", i, exp_high_len(ws));
      chk(lcd_en == hit, "R7 R5 enable decode", int'(lcd_en), int'(hit));
      chk(rs == a[0], "R6 rs held", int'(rs), int'(a[0]));
      if (wr) chk(ad_oe && ad_out == d, "R3 data through E", int'(ad_out), int'(d));
      chk(req_ready == 1'b0, "R8 busy during E", int'(req_ready), 0);
    end
    @(negedge clk);
    chk(e_clk == 1'b0 && lcd_en == 1'b0, "R9 E falls on time", int'(e_clk), 0);
    if (wr) chk(ad_oe && ad_out == d, "R3 data after E falls", int'(ad_out), int'(d));
    chk(req_ready == 1'b0, "R8 busy in hold", int'(req_ready), 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready after cycle", int'(req_ready), 1);
    chk(!ad_oe && rw, "R3 bus released", int'(ad_oe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic s [8];
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!e_clk && !lcd_en && !ale && rw && !ad_oe, "R1 idle levels in reset",
        int'({e_clk, lcd_en, ale, rw, ad_oe}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!e_clk && !lcd_en && !ale && rw && !ad_oe && req_ready,
        "R1 idle levels after reset", int'({e_clk, lcd_en, ale, rw, ad_oe}), 2);
    for (int i = 0; i < 8; i++) begin
      s[i] = e_clk;
      @(negedge clk);
    end
    for (int i = 0; i < 6; i++)
      chk(s[i] != s[i+2], "R4 free E two low two high", int'(s[i]), int'(!s[i+2]));

    run_cycle(16'h3000, 8'h38, 1'b1, 0, 1'b0);
    run_cycle(16'h3001, 8'h41, 1'b1, 0, 1'b0);
    run_cycle(16'h3FFF, 8'hA5, 1'b1, 1, 1'b0);
    run_cycle(16'h2FFF, 8'h5A, 1'b1, 0, 1'b0);
    run_cycle(16'h4000, 8'h11, 1'b1, 2, 1'b0);
    run_cycle(16'h3000, 8'h00, 1'b0, 3, 1'b0);
    run_cycle(16'h3002, 8'hC3, 1'b1, 3, 1'b1);
    for (int k = 0; k < 50; k++) begin
      logic [15:0] a;
      if ($urandom % 2) a = {4'h3, 12'($urandom)};
      else              a = 16'($urandom);
      run_cycle(a, 8'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom % 4 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule